// File: doc/BRIEF.md
# SPI byte-stream to Wishbone bridge

This block sits in the bus clock domain behind an SPI slave receiver. That receiver has already crossed each received byte into this domain. The block turns a short byte frame from a host microcontroller into one Wishbone classic bus cycle.

The first byte of a frame is a header, laid out as W000SSSS:
- W (bit 7) selects a write.
- SSSS (bits 3..0) are the byte lanes.

An address byte follows the header. For a write, four data bytes follow the address, most significant byte first. The bridge then issues the bus cycle and answers through the SPI transmitter. It sends 0xFF while the cycle is outstanding, then a single 0x00 once the slave acknowledges. For a read, the four result bytes follow the 0x00, most significant first.

The host keeps clocking filler bytes while it waits, and the bridge ignores their contents. Releasing chip select ends the frame at any point.

Timing of the transmit side: the transmitter loads `tx_byte_o` in each cycle that `rx_valid_i` is high. That byte goes out in the next byte slot of the frame.

Top module: `spi_wb_bridge`

## Requirements
- R1: After reset, `wb_cyc_o` and `wb_stb_o` are low and `tx_byte_o` is 0xFF.
- R2: In the header byte, bit 7 drives `wb_we_o` and bits 3..0 drive `wb_sel_o`, with bit 0 the least significant lane. Bits 6..4 are ignored. The next byte drives `wb_adr_o`.
- R3: In a write, the four data bytes after the address form `wb_dat_o`, the first byte at bits 31..24. The bus cycle starts in the clock after the `rx_valid_i` cycle of the fourth data byte.
- R4: In a read, the bus cycle starts in the clock after the `rx_valid_i` cycle of the address byte.
- R5: `wb_cyc_o` and `wb_stb_o` rise and fall together. They stay high until a cycle in which `wb_ack_i` is high and are low in the next clock. `wb_we_o`, `wb_sel_o`, `wb_adr_o` and `wb_dat_o` do not change while the cycle waits.
- R6: `tx_byte_o` is 0xFF from the start of the frame until the acknowledge, including the byte sampled in the starting `rx_valid_i` cycle. At the first `rx_valid_i` after the acknowledge cycle it is 0x00, exactly once.
- R7: Read data is captured in the acknowledge cycle. It is presented in the four `rx_valid_i` cycles after the 0x00 byte, most significant byte first. After that `tx_byte_o` is 0xFF until the frame ends.
- R8: The contents of bytes received after the command bytes have no effect. `rx_valid_i` has no effect while `cs_i` is low.
- R9: When `cs_i` is low, in the next clock the decoder is back at the header byte and `wb_cyc_o`/`wb_stb_o` are low. A cycle that has not started is never issued, and a running cycle is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high, already synchronised |
| rx_valid_i | input | 1 | One-cycle strobe per received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Byte for the next transmit slot |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_adr_o | output | 8 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
A decoder that loses its place in the frame shows at the ports as a bus cycle one or more bytes early or late. It can also show as a wrong address, lane or data word on the bus. Both are visible in the clock after the byte that should have started the cycle.

A wrong acknowledge flag or a wrong byte index shows up in `tx_byte_o` at the very next `rx_valid_i`. Typical symptoms are a missing or doubled 0x00, or data bytes rotated out of order. State left behind by an aborted frame appears as a spurious cycle, or as a wrong reply byte in the first frame after chip select returns.

// File: rtl/spi_wb_pkg.sv
package spi_wb_pkg;
  typedef enum logic [2:0] {
    ST_HDR,
    ST_ADR,
    ST_WDAT,
    ST_BUSY,
    ST_RDAT,
    ST_END
  } frame_st_e;

  localparam logic [7:0] BYTE_WAIT = 8'hFF;
  localparam logic [7:0] BYTE_ACK  = 8'h00;
endpackage

// File: rtl/spi_wb_decoder.sv
module spi_wb_decoder
  import spi_wb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int CNT_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              done_i,
  output frame_st_e         state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              we_o,
  output logic [NB-1:0]     sel_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] wdat_o,
  output logic              start_o
);
  frame_st_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              we_q;
  logic [NB-1:0]     sel_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              last_byte;
  logic              unused_hdr;

  assign last_byte  = (cnt_q == CNT_W'(NB - 1));
  assign unused_hdr = ^rx_byte_i[6:4];

  // launch point of the bus cycle
  assign start_o = cs_i & rx_valid_i &
                   (((state_q == ST_ADR) & ~we_q) | ((state_q == ST_WDAT) & last_byte));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      sel_q   <= '0;
      adr_q   <= '0;
      wdat_q  <= '0;
    end else if (!cs_i) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_HDR: begin
          we_q    <= rx_byte_i[7];
          sel_q   <= rx_byte_i[NB-1:0];
          state_q <= ST_ADR;
        end
        ST_ADR: begin
          adr_q   <= rx_byte_i[ADDR_W-1:0];
          cnt_q   <= '0;
          state_q <= we_q ? ST_WDAT : ST_BUSY;
        end
        ST_WDAT: begin
          wdat_q <= {wdat_q[DATA_W-9:0], rx_byte_i};
          cnt_q  <= cnt_q + 1'b1;
          if (last_byte) state_q <= ST_BUSY;
        end
        ST_BUSY: begin
          cnt_q <= '0;
          if (done_i) state_q <= we_q ? ST_END : ST_RDAT;
        end
        ST_RDAT: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_byte) state_q <= ST_END;
        end
        default: state_q <= ST_END;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign we_o    = we_q;
  assign sel_o   = sel_q;
  assign adr_o   = adr_q;
  assign wdat_o  = wdat_q;
endmodule

// File: rtl/spi_wb_busport.sv
module spi_wb_busport #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              cyc_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdat_o
);
  logic              cyc_q;
  logic              done_q;
  logic [DATA_W-1:0] rdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= 1'b0;
      done_q <= 1'b0;
      rdat_q <= '0;
    end else if (!cs_i) begin
      cyc_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cyc_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (cyc_q && ack_i) begin
      cyc_q  <= 1'b0;
      done_q <= 1'b1;
      rdat_q <= dat_i;
    end
  end

  assign cyc_o  = cyc_q;
  assign done_o = done_q;
  assign rdat_o = rdat_q;
endmodule

// File: rtl/spi_wb_reply.sv
module spi_wb_reply
  import spi_wb_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int CNT_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  frame_st_e         state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdat_i,
  output logic [7:0]        tx_byte_o
);
  logic [7:0] rbyte [NB];

  // lane 0 of the array is the most significant byte
  for (genvar i = 0; i < NB; i++) begin : g_split
    assign rbyte[i] = rdat_i[DATA_W-1-8*i -: 8];
  end

  always_comb begin
    unique case (state_i)
      ST_BUSY: tx_byte_o = done_i ? BYTE_ACK : BYTE_WAIT;
      ST_RDAT: tx_byte_o = rbyte[cnt_i];
      default: tx_byte_o = BYTE_WAIT;
    endcase
  end
endmodule

// File: rtl/spi_wb_bridge.sv
module spi_wb_bridge
  import spi_wb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_i,
  input  logic                  rx_valid_i,
  input  logic [7:0]            rx_byte_i,
  output logic [7:0]            tx_byte_o,
  output logic                  wb_cyc_o,
  output logic                  wb_stb_o,
  output logic                  wb_we_o,
  output logic [DATA_W/8-1:0]   wb_sel_o,
  output logic [ADDR_W-1:0]     wb_adr_o,
  output logic [DATA_W-1:0]     wb_dat_o,
  input  logic [DATA_W-1:0]     wb_dat_i,
  input  logic                  wb_ack_i
);
  localparam int NB    = DATA_W / 8;
  localparam int CNT_W = (NB > 1) ? $clog2(NB) : 1;

  frame_st_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              start;
  logic              done;
  logic              cyc;
  logic [DATA_W-1:0] rdat;

  spi_wb_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .rx_valid_i(rx_valid_i),
    .rx_byte_i (rx_byte_i),
    .done_i    (done),
    .state_o   (state),
    .cnt_o     (cnt),
    .we_o      (wb_we_o),
    .sel_o     (wb_sel_o),
    .adr_o     (wb_adr_o),
    .wdat_o    (wb_dat_o),
    .start_o   (start)
  );

  spi_wb_busport #(.DATA_W(DATA_W)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .start_i(start),
    .ack_i  (wb_ack_i),
    .dat_i  (wb_dat_i),
    .cyc_o  (cyc),
    .done_o (done),
    .rdat_o (rdat)
  );

  spi_wb_reply #(.DATA_W(DATA_W)) u_rep (
    .state_i  (state),
    .cnt_i    (cnt),
    .done_i   (done),
    .rdat_i   (rdat),
    .tx_byte_o(tx_byte_o)
  );

  assign wb_cyc_o = cyc;
  assign wb_stb_o = cyc;
endmodule

// File: rtl/spi_wb_bridge_chk.sv
module spi_wb_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_i,
  input logic [7:0]          tx_byte_o,
  input logic                wb_cyc_o,
  input logic                wb_stb_o,
  input logic                wb_we_o,
  input logic [DATA_W/8-1:0] wb_sel_o,
  input logic [ADDR_W-1:0]   wb_adr_o,
  input logic [DATA_W-1:0]   wb_dat_o,
  input logic                wb_ack_i
);
  p_hold_until_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !wb_ack_i && cs_i) |=> (wb_cyc_o && wb_stb_o));

  p_drop_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i) |=> (!wb_cyc_o && !wb_stb_o));

  p_stable_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !wb_ack_i && cs_i) |=>
      ($stable(wb_we_o) && $stable(wb_sel_o) && $stable(wb_adr_o) && $stable(wb_dat_o)));

  p_wait_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_o |-> (tx_byte_o == 8'hFF));

  p_ack_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i && cs_i) |=> (!cs_i || tx_byte_o == 8'h00));

  p_cs_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (!wb_cyc_o && !wb_stb_o));
endmodule

bind spi_wb_bridge spi_wb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_i     (cs_i),
  .tx_byte_o(tx_byte_o),
  .wb_cyc_o (wb_cyc_o),
  .wb_stb_o (wb_stb_o),
  .wb_we_o  (wb_we_o),
  .wb_sel_o (wb_sel_o),
  .wb_adr_o (wb_adr_o),
  .wb_dat_o (wb_dat_o),
  .wb_ack_i (wb_ack_i)
);

// File: tb/spi_wb_bridge_test.sv
`timescale 1ns/1ps
module spi_wb_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        rxv = 1'b0;
  logic [7:0]  rxb = 8'h00;
  logic [7:0]  tx;
  logic        cyc, stb, we;
  logic [3:0]  sel;
  logic [7:0]  adr;
  logic [31:0] dat_o, dat_i;
  logic        ack_r;

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int lat_cnt;
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  spi_wb_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rx_valid_i(rxv), .rx_byte_i(rxb),
    .tx_byte_o(tx), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_sel_o(sel),
    .wb_adr_o(adr), .wb_dat_o(dat_o), .wb_dat_i(dat_i), .wb_ack_i(ack_r)
  );

  // bus slave with programmable latency
  assign dat_i = ack_r ? mem[adr] : 32'h0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_r   <= 1'b0;
      lat_cnt <= 0;
    end else if (cyc && stb && !ack_r) begin
      if (lat_cnt >= lat) begin
        ack_r   <= 1'b1;
        lat_cnt <= 0;
        if (we) for (int i = 0; i < 4; i++) if (sel[i]) mem[adr][8*i +: 8] <= dat_o[8*i +: 8];
      end else lat_cnt <= lat_cnt + 1;
    end else begin
      ack_r   <= 1'b0;
      lat_cnt <= 0;
    end
  end

  // behavioural reference model
  int          m_pos, m_post;
  logic        m_we, m_cyc, m_acked;
  logic [3:0]  m_sel;
  logic [7:0]  m_adr;
  logic [31:0] m_word, m_rword;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos <= 0; m_post <= 0; m_we <= 0; m_cyc <= 0; m_acked <= 0;
      m_sel <= 0; m_adr <= 0; m_word <= 0; m_rword <= 0;
    end else if (!cs) begin
      m_pos <= 0; m_post <= 0; m_cyc <= 0; m_acked <= 0;
    end else begin
      if (m_cyc && ack_r) begin
        m_cyc   <= 1'b0;
        m_acked <= 1'b1;
        m_rword <= mem[m_adr];
      end
      if (rxv) begin
        m_pos <= m_pos + 1;
        if (m_acked) m_post <= m_post + 1;
        if (m_pos == 0) begin m_we <= rxb[7]; m_sel <= rxb[3:0]; end
        if (m_pos == 1) m_adr <= rxb;
        if (m_pos == 1 && !m_we) m_cyc <= 1'b1;
        if (m_we && m_pos >= 2 && m_pos <= 5) m_word <= {m_word[23:0], rxb};
        if (m_we && m_pos == 5) m_cyc <= 1'b1;
      end
    end
  end

  function automatic logic [7:0] m_exp();
    if (!m_acked) return 8'hFF;
    if (m_post == 0) return 8'h00;
    if (!m_we && m_post <= 4) return m_rword[31 - 8*(m_post-1) -: 8];
    return 8'hFF;
  endfunction

  // per-clock comparison of the bus side
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (cyc !== m_cyc || stb !== m_cyc) begin
        fails++;
        $display("FAIL R5 cyc/stb: actual %b/%b expected %b (R3 R4 R9 timing)", cyc, stb, m_cyc);
      end
      if (m_cyc) begin
        checks++;
        if (adr !== m_adr || we !== m_we || sel !== m_sel || (m_we && dat_o !== m_word)) begin
          fails++;
          $display("FAIL R2 R3 fields: actual adr %h we %b sel %h dat %h expected adr %h we %b sel %h dat %h",
                   adr, we, sel, dat_o, m_adr, m_we, m_sel, m_word);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one byte exchange; tx value of the strobe cycle is the reply
  task automatic xfer(input logic [7:0] b, input int gap, output logic [7:0] r);
    logic [7:0] e;
    @(negedge clk);
    rxb = b;
    rxv = 1'b1;
    r = tx;
    e = m_exp();
    check("R6 R7 reply byte", {24'h0, r}, {24'h0, e});
    @(negedge clk);
    rxv = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] hdr, input logic [7:0] a, input logic [31:0] d,
                       input int gap, input logic [7:0] dummy, output logic [31:0] rd);
    logic [7:0] r;
    bit got;
    cs = 1'b1;
    idle(1);
    xfer(hdr, gap, r);
    xfer(a, gap, r);
    if (hdr[7]) for (int i = 3; i >= 0; i--) xfer(d[8*i +: 8], gap, r);
    got = 0;
    for (int k = 0; k < 100 && !got; k++) begin
      xfer(dummy, gap, r);
      if (r == 8'h00) got = 1;
    end
    check("R6 ack byte seen", {31'h0, got}, 32'h1);
    rd = 32'h0;
    if (!hdr[7]) for (int i = 3; i >= 0; i--) begin
      xfer(dummy, gap, r);
      rd[8*i +: 8] = r;
    end
    xfer(dummy, gap, r);
    check("R7 trailing wait byte", {24'h0, r}, 32'hFF);
    idle(1);
    cs = 1'b0;
    idle(2);
  endtask

  initial begin : main
    logic [31:0] rd;
    logic [7:0] r;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    idle(3);
    check("R1 reset tx", {24'h0, tx}, 32'hFF);
    check("R1 reset cyc", {30'h0, cyc, stb}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    check("R1 idle tx", {24'h0, tx}, 32'hFF);

    // R3: basic write, immediate ack
    lat = 0;
    frame(8'h8F, 8'h00, 32'h12345678, 2, 8'h00, rd);
    check("R3 write word", mem[0], 32'h12345678);

    // R4 R7: read back with latency
    lat = 3;
    frame(8'h0F, 8'h00, 32'h0, 1, 8'hA5, rd);
    check("R7 read data order", rd, 32'h12345678);

    // R2: reserved header bits set, partial lanes 0 and 2
    lat = 1;
    frame(8'hF5, 8'h10, 32'hAABBCCDD, 1, 8'h3C, rd);
    check("R2 lane select", mem[16], 32'h00BB00DD);

    // R6: long wait stream, back to back bytes
    lat = 25;
    frame(8'h0F, 8'h10, 32'h0, 0, 8'hFF, rd);
    check("R7 read after long wait", rd, 32'h00BB00DD);

    // R6: ack at once, bytes back to back, still one wait byte first
    lat = 0;
    frame(8'h8F, 8'hFE, 32'hCAFEF00D, 0, 8'h00, rd);
    check("R3 write back to back", mem[254], 32'hCAFEF00D);

    // R8: strobes with chip select low are ignored
    xfer(8'h8F, 0, r);
    xfer(8'h01, 0, r);
    check("R8 no cycle while deselected", {31'h0, cyc}, 32'h0);
    frame(8'h0F, 8'hFE, 32'h0, 1, 8'h00, rd);
    check("R8 read after ignored strobes", rd, 32'hCAFEF00D);

    // R9: release mid-frame before the cycle starts
    cs = 1'b1;
    idle(1);
    xfer(8'h8F, 1, r);
    xfer(8'h20, 1, r);
    xfer(8'h11, 1, r);
    cs = 1'b0;
    idle(3);
    frame(8'h0F, 8'h20, 32'h0, 1, 8'h00, rd);
    check("R9 aborted write not issued", rd, 32'h0);

    // R9: release during a running cycle
    lat = 40;
    cs = 1'b1;
    idle(1);
    xfer(8'h8F, 0, r);
    xfer(8'h30, 0, r);
    for (int i = 0; i < 4; i++) xfer(8'h55, 0, r);
    idle(3);
    check("R9 cycle running", {31'h0, cyc}, 32'h1);
    cs = 1'b0;
    idle(1);
    check("R9 cycle dropped", {31'h0, cyc}, 32'h0);
    idle(2);
    lat = 0;
    frame(8'h0F, 8'h30, 32'h0, 1, 8'h00, rd);
    check("R9 abandoned write left no data", rd, 32'h0);
    check("R9 earlier data intact", mem[0], 32'h12345678);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule